// File: doc/BRIEF.md
# In-Order Retirement List with Register Reclamation

This block keeps a program-ordered record of every decoded instruction in an out-of-order core that renames registers. At decode, each new instruction claims a slot at the tail. The slot stores the architectural destination and the physical register that held that destination's value before the rename. The slot number goes back to decode as the instruction's tag. Functional units later report completion by tag, in any order, and may flag an exception with it.

Instructions leave from the head strictly in program order. Up to four leave per cycle, and only while every entry up to that point has completed cleanly. Each departing entry hands its displaced physical register to the free-list port, because no instruction can read that older value any more. A completed entry with an exception at the head stops retirement and is reported with its tag. A flush discards every outstanding entry in one cycle. Rollback of the rename map and the free list itself are handled outside this block.

Top module: `active_list`

## Requirements
- R1: While reset is held and after it is released, `empty_o` is 1, `full_o` is 0, `ret_valid_o` is 0 and `exc_valid_o` is 0.
- R2: An allocation request must occupy lanes contiguously from lane 0. It is accepted as a whole only when the number of free slots is at least the number of lanes requested; otherwise no lane is accepted. Lane i receives tag (tail + i) mod 32, where tail is the next free slot, and the tag advances by one per accepted entry.
- R3: `full_o` is 1 exactly when all 32 slots are occupied. `empty_o` is 1 exactly when none are occupied.
- R4: Completions may arrive in any order. Entries retire in allocation order, and each retired lane reports that entry's tag and destination.
- R5: At most four entries retire per cycle. The set bits of `ret_valid_o` are contiguous from lane 0, with the oldest entry in lane 0.
- R6: For each retiring lane, `free_valid_o` is 1 only if the entry recorded a prior physical register. In that case `free_preg_o` carries the number that was recorded.
- R7: When the head entry has completed with its exception flag set, `exc_valid_o` is 1 with `exc_tag_o` equal to its tag. Nothing retires and no register is freed. This state persists until a flush.
- R8: In a cycle with `flush_i` high, no allocation is accepted and nothing retires. From the next cycle the list is empty, and the next tag equals the head slot.
- R9: A completed entry does not retire while any older entry has not completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 4 | Allocation request per lane, contiguous from lane 0 |
| alloc_ldst_i | input | 20 | Destination logical register per lane (5 bits each) |
| alloc_has_old_i | input | 4 | Lane has a displaced physical register |
| alloc_old_preg_i | input | 28 | Displaced physical register per lane (7 bits each) |
| alloc_accept_o | output | 1 | Request of this cycle is accepted |
| alloc_tag_o | output | 20 | Tag offered to each lane (5 bits each) |
| cmpl_valid_i | input | 2 | Completion strobe per write-back port |
| cmpl_exc_i | input | 2 | Completion carries an exception |
| cmpl_tag_i | input | 10 | Tag being completed per port (5 bits each) |
| flush_i | input | 1 | Discard all outstanding entries |
| ret_valid_o | output | 4 | Retiring lanes this cycle |
| ret_tag_o | output | 20 | Tag of each retiring lane |
| ret_ldst_o | output | 20 | Destination register of each retiring lane |
| free_valid_o | output | 4 | Physical register released per lane |
| free_preg_o | output | 28 | Released physical register per lane |
| exc_valid_o | output | 1 | Head entry holds an exception |
| exc_tag_o | output | 5 | Tag of the excepting head entry |
| full_o | output | 1 | All slots occupied |
| empty_o | output | 1 | No slot occupied |

## Verification
The bench fills the list to exactly 32 entries. It requests two lanes when only one slot is free, and one lane when none is free. A design that counted free slots off by one, or accepted a partial group, would give a wrong tag or admit an entry that overwrites the head. It completes younger entries first and checks that nothing leaves until the oldest one completes; a design that retired each entry on its own done bit would release registers out of order. It also checks the four-lane limit across a six-entry burst, an excepting head that must free nothing and hold until flushed, and a long random run. In that run the bench compares every retired tag and freed register against a simple queue model.

// File: rtl/al_pkg.sv
package al_pkg;
  localparam int unsigned LREG_W = 5;
  localparam int unsigned PREG_W = 7;

  typedef struct packed {
    logic [LREG_W-1:0] ldst;
    logic              has_old;
    logic [PREG_W-1:0] old_preg;
  } al_entry_t;
endpackage

// File: rtl/al_ptr.sv
// Ring pointer with one extra wrap bit; load wins over advance.
module al_ptr #(
  parameter int unsigned PTR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  input  logic [PTR_W-1:0] step_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else             ptr_q <= ptr_q + step_i;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/al_retire_sel.sv
// Picks the retiring prefix of the head window.
module al_retire_sel #(
  parameter int unsigned LANES = 4,
  parameter int unsigned CNT_W = 6
) (
  input  logic             en_i,
  input  logic [CNT_W-1:0] avail_i,
  input  logic [LANES-1:0] done_i,
  input  logic [LANES-1:0] exc_i,
  output logic [LANES-1:0] ret_o,
  output logic             head_exc_o
);
  always_comb begin
    logic run;
    run = en_i;
    for (int i = 0; i < LANES; i++) begin
      logic ok;
      ok = (CNT_W'(i) < avail_i) && done_i[i] && !exc_i[i];
      ret_o[i] = run && ok;
      run = run && ok;
    end
  end

  assign head_exc_o = (avail_i != '0) && done_i[0] && exc_i[0];
endmodule

// File: rtl/active_list.sv
module active_list
  import al_pkg::*;
#(
  parameter int unsigned DEPTH   = 32,
  parameter int unsigned ALLOC_W = 4,
  parameter int unsigned RET_W   = 4,
  parameter int unsigned CMPL_W  = 2,
  parameter int unsigned IDX_W   = $clog2(DEPTH)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ALLOC_W-1:0]        alloc_valid_i,
  input  logic [ALLOC_W*LREG_W-1:0] alloc_ldst_i,
  input  logic [ALLOC_W-1:0]        alloc_has_old_i,
  input  logic [ALLOC_W*PREG_W-1:0] alloc_old_preg_i,
  output logic                      alloc_accept_o,
  output logic [ALLOC_W*IDX_W-1:0]  alloc_tag_o,
  input  logic [CMPL_W-1:0]         cmpl_valid_i,
  input  logic [CMPL_W-1:0]         cmpl_exc_i,
  input  logic [CMPL_W*IDX_W-1:0]   cmpl_tag_i,
  input  logic                      flush_i,
  output logic [RET_W-1:0]          ret_valid_o,
  output logic [RET_W*IDX_W-1:0]    ret_tag_o,
  output logic [RET_W*LREG_W-1:0]   ret_ldst_o,
  output logic [RET_W-1:0]          free_valid_o,
  output logic [RET_W*PREG_W-1:0]   free_preg_o,
  output logic                      exc_valid_o,
  output logic [IDX_W-1:0]          exc_tag_o,
  output logic                      full_o,
  output logic                      empty_o
);
  localparam int unsigned PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] head, tail, count, free_cnt, req_n, ret_n;
  logic             alloc_go;
  al_entry_t        ent_q [DEPTH];
  logic [DEPTH-1:0] done_q, exc_q;

  logic [IDX_W-1:0] alloc_slot [ALLOC_W];
  al_entry_t        alloc_ent  [ALLOC_W];
  logic [IDX_W-1:0] win_slot   [RET_W];
  al_entry_t        win_ent    [RET_W];
  logic [RET_W-1:0] win_done, win_exc;

  assign count    = tail - head;
  assign free_cnt = PTR_W'(DEPTH) - count;
  assign req_n    = PTR_W'($countones(alloc_valid_i));
  assign ret_n    = PTR_W'($countones(ret_valid_o));
  assign full_o   = (count == PTR_W'(DEPTH));
  assign empty_o  = (count == '0);

  // Whole group or nothing; flush blocks decode.
  assign alloc_accept_o = !flush_i && (req_n <= free_cnt);
  assign alloc_go       = alloc_accept_o && (req_n != '0);

  al_ptr #(.PTR_W(PTR_W)) u_head (
    .clk_i, .rst_ni,
    .load_i     (1'b0),
    .load_val_i ('0),
    .step_i     (ret_n),
    .ptr_o      (head)
  );

  al_ptr #(.PTR_W(PTR_W)) u_tail (
    .clk_i, .rst_ni,
    .load_i     (flush_i),
    .load_val_i (head),
    .step_i     (alloc_go ? req_n : '0),
    .ptr_o      (tail)
  );

  generate
    for (genvar a = 0; a < ALLOC_W; a++) begin : g_alloc
      assign alloc_slot[a] = tail[IDX_W-1:0] + IDX_W'(a);
      assign alloc_tag_o[a*IDX_W +: IDX_W] = alloc_slot[a];
      assign alloc_ent[a] = '{ldst:     alloc_ldst_i[a*LREG_W +: LREG_W],
                              has_old:  alloc_has_old_i[a],
                              old_preg: alloc_old_preg_i[a*PREG_W +: PREG_W]};
    end

    for (genvar r = 0; r < RET_W; r++) begin : g_win
      assign win_slot[r] = head[IDX_W-1:0] + IDX_W'(r);
      assign win_ent[r]  = ent_q[win_slot[r]];
      assign win_done[r] = done_q[win_slot[r]];
      assign win_exc[r]  = exc_q[win_slot[r]];
      assign ret_tag_o[r*IDX_W +: IDX_W]     = win_slot[r];
      assign ret_ldst_o[r*LREG_W +: LREG_W]  = win_ent[r].ldst;
      assign free_valid_o[r]                 = ret_valid_o[r] && win_ent[r].has_old;
      assign free_preg_o[r*PREG_W +: PREG_W] = win_ent[r].old_preg;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    for (int a = 0; a < ALLOC_W; a++)
      if (alloc_go && alloc_valid_i[a]) ent_q[alloc_slot[a]] <= alloc_ent[a];
  end

  // Status bits: new entries start clear, write-back sets them.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= '0;
      exc_q  <= '0;
    end else begin
      for (int a = 0; a < ALLOC_W; a++)
        if (alloc_go && alloc_valid_i[a]) begin
          done_q[alloc_slot[a]] <= 1'b0;
          exc_q[alloc_slot[a]]  <= 1'b0;
        end
      for (int c = 0; c < CMPL_W; c++)
        if (cmpl_valid_i[c]) begin
          done_q[cmpl_tag_i[c*IDX_W +: IDX_W]] <= 1'b1;
          exc_q[cmpl_tag_i[c*IDX_W +: IDX_W]]  <= cmpl_exc_i[c];
        end
    end
  end

  al_retire_sel #(.LANES(RET_W), .CNT_W(PTR_W)) u_sel (
    .en_i       (!flush_i),
    .avail_i    (count),
    .done_i     (win_done),
    .exc_i      (win_exc),
    .ret_o      (ret_valid_o),
    .head_exc_o (exc_valid_o)
  );

  assign exc_tag_o = head[IDX_W-1:0];

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= PTR_W'(DEPTH));

  assert_alloc_contig_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((alloc_valid_i + ALLOC_W'(1)) & alloc_valid_i) == '0);

  assert_exc_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> (ret_valid_o == '0) && (free_valid_o == '0));

  assert_free_on_retire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_valid_o & ~ret_valid_o) == '0);

  assert_flush_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);

  assert_ret_nonempty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o[0] |-> !empty_o);

  generate
    for (genvar r = 1; r < RET_W; r++) begin : g_chk
      assert_ret_contig_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ret_valid_o[r] |-> ret_valid_o[r-1]);
    end
  endgenerate
endmodule

// File: tb/sim_active_list.sv
module sim_active_list;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [3:0]  alloc_valid_i;
  logic [19:0] alloc_ldst_i;
  logic [3:0]  alloc_has_old_i;
  logic [27:0] alloc_old_preg_i;
  logic        alloc_accept_o;
  logic [19:0] alloc_tag_o;
  logic [1:0]  cmpl_valid_i, cmpl_exc_i;
  logic [9:0]  cmpl_tag_i;
  logic        flush_i;
  logic [3:0]  ret_valid_o;
  logic [19:0] ret_tag_o, ret_ldst_o;
  logic [3:0]  free_valid_o;
  logic [27:0] free_preg_o;
  logic        exc_valid_o;
  logic [4:0]  exc_tag_o;
  logic        full_o, empty_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk_i = ~clk_i;

  active_list u0 (.*);

  // {lanes[8:6], accept[5], first tag[4:0]} starting from empty
  localparam logic [8:0] ALLOC_VEC [11] = '{
    {3'd4, 1'b1, 5'd0},  {3'd4, 1'b1, 5'd4},  {3'd4, 1'b1, 5'd8},
    {3'd4, 1'b1, 5'd12}, {3'd4, 1'b1, 5'd16}, {3'd4, 1'b1, 5'd20},
    {3'd4, 1'b1, 5'd24}, {3'd3, 1'b1, 5'd28}, {3'd2, 1'b0, 5'd31},
    {3'd1, 1'b1, 5'd31}, {3'd1, 1'b0, 5'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    alloc_valid_i = '0; alloc_ldst_i = '0; alloc_has_old_i = '0; alloc_old_preg_i = '0;
    cmpl_valid_i = '0; cmpl_exc_i = '0; cmpl_tag_i = '0; flush_i = 1'b0;
  endtask

  task automatic set_lane(input int i, input int ldst, input bit has, input int preg);
    alloc_valid_i[i] = 1'b1;
    alloc_ldst_i[i*5 +: 5] = 5'(ldst);
    alloc_has_old_i[i] = has;
    alloc_old_preg_i[i*7 +: 7] = 7'(preg);
  endtask

  task automatic set_cmpl(input int p, input int tag, input bit exc);
    cmpl_valid_i[p] = 1'b1;
    cmpl_tag_i[p*5 +: 5] = 5'(tag);
    cmpl_exc_i[p] = exc;
  endtask

  task automatic do_reset();
    idle();
    rst_ni = 1'b0;
    #1;
    chk(empty_o && !full_o && ret_valid_o == 0 && !exc_valid_o, "R1", int'(empty_o), 1);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(empty_o && !full_o && ret_valid_o == 0 && !exc_valid_o, "R1", int'(ret_valid_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  int q[$];
  logic [4:0] m_ldst [32];
  bit         m_has  [32];
  logic [6:0] m_preg [32];
  bit         m_done [32];

  initial begin
    @(negedge clk_i);
    do_reset();

    // Fill to exactly full via the vector table
    foreach (ALLOC_VEC[v]) begin
      int n;
      n = int'(ALLOC_VEC[v][8:6]);
      idle();
      for (int i = 0; i < n; i++) set_lane(i, v, 1'b1, v);
      #1;
      chk(alloc_accept_o == ALLOC_VEC[v][5], "R2", int'(alloc_accept_o), int'(ALLOC_VEC[v][5]));
      chk(alloc_tag_o[4:0] == ALLOC_VEC[v][4:0], "R2", int'(alloc_tag_o[4:0]), int'(ALLOC_VEC[v][4:0]));
      tick();
    end
    idle();
    #1;
    chk(full_o && !empty_o, "R3", int'(full_o), 1);

    // Flush while requesting: nothing taken, then empty
    flush_i = 1'b1;
    set_lane(0, 1, 1'b1, 1);
    #1;
    chk(!alloc_accept_o && ret_valid_o == 0, "R8", int'(alloc_accept_o), 0);
    tick();
    idle();
    #1;
    chk(empty_o && !full_o, "R8", int'(empty_o), 1);
    chk(alloc_tag_o[4:0] == 5'd0, "R8", int'(alloc_tag_o[4:0]), 0);

    // Younger completions wait for the oldest
    set_lane(0, 1, 1'b1, 10);
    set_lane(1, 2, 1'b0, 11);
    set_lane(2, 3, 1'b1, 12);
    tick();
    idle();
    set_cmpl(0, 2, 1'b0);
    set_cmpl(1, 1, 1'b0);
    tick();
    idle();
    #1;
    chk(ret_valid_o == 0, "R9", int'(ret_valid_o), 0);
    tick();
    chk(ret_valid_o == 0, "R9", int'(ret_valid_o), 0);
    set_cmpl(0, 0, 1'b0);
    tick();
    idle();
    #1;
    chk(ret_valid_o == 4'b0111, "R4", int'(ret_valid_o), 7);
    chk(ret_tag_o[14:0] == {5'd2, 5'd1, 5'd0}, "R4", int'(ret_tag_o[14:0]), 32'h0820);
    chk(ret_ldst_o[9:5] == 5'd2, "R4", int'(ret_ldst_o[9:5]), 2);
    chk(free_valid_o == 4'b0101, "R6", int'(free_valid_o), 5);
    chk(free_preg_o[6:0] == 7'd10 && free_preg_o[20:14] == 7'd12, "R6",
        int'(free_preg_o[20:14]), 12);
    tick();
    chk(empty_o, "R4", int'(empty_o), 1);

    // Exception at head
    set_lane(0, 5, 1'b1, 20);
    set_lane(1, 6, 1'b1, 21);
    tick();
    idle();
    set_cmpl(0, 3, 1'b1);
    set_cmpl(1, 4, 1'b0);
    tick();
    idle();
    #1;
    chk(exc_valid_o && exc_tag_o == 5'd3, "R7", int'(exc_tag_o), 3);
    chk(ret_valid_o == 0 && free_valid_o == 0, "R7", int'(free_valid_o), 0);
    tick();
    chk(exc_valid_o && !empty_o && ret_valid_o == 0, "R7", int'(exc_valid_o), 1);
    flush_i = 1'b1;
    tick();
    idle();
    #1;
    chk(!exc_valid_o && empty_o, "R8", int'(exc_valid_o), 0);

    // Six completed entries leave as four then two
    for (int i = 0; i < 4; i++) set_lane(i, i, 1'b1, 30 + i);
    tick();
    idle();
    set_lane(0, 4, 1'b1, 34);
    set_lane(1, 5, 1'b1, 35);
    tick();
    idle();
    set_cmpl(0, 8, 1'b0); set_cmpl(1, 7, 1'b0); tick();
    set_cmpl(0, 6, 1'b0); set_cmpl(1, 5, 1'b0); tick();
    set_cmpl(0, 4, 1'b0); set_cmpl(1, 3, 1'b0); tick();
    idle();
    #1;
    chk(ret_valid_o == 4'b1111, "R5", int'(ret_valid_o), 15);
    chk(ret_tag_o[4:0] == 5'd3 && ret_tag_o[19:15] == 5'd6, "R5", int'(ret_tag_o[19:15]), 6);
    tick();
    chk(ret_valid_o == 4'b0011 && ret_tag_o[4:0] == 5'd7, "R5", int'(ret_valid_o), 3);
    tick();
    chk(empty_o, "R5", int'(empty_o), 1);

    // Random out-of-order completion against a queue model
    do_reset();
    q.delete();
    begin
      int mt;
      mt = 0;
      for (int cyc = 0; cyc < 3000; cyc++) begin
        int exp_n, k, cp[2];
        bit acc;
        idle();
        exp_n = 0;
        while (exp_n < 4 && exp_n < q.size() && m_done[q[exp_n]]) exp_n++;
        k = $urandom_range(0, 4);
        acc = (q.size() + k) <= 32;
        for (int i = 0; i < k; i++)
          set_lane(i, $urandom_range(0, 31), 1'($urandom_range(0, 1)), $urandom_range(0, 127));
        cp = '{-1, -1};
        for (int p = 0; p < 2; p++) begin
          if (q.size() > 0 && $urandom_range(0, 9) < 7) begin
            for (int t = 0; t < 6; t++) begin
              int tg;
              tg = q[$urandom_range(0, q.size() - 1)];
              if (!m_done[tg] && tg != cp[0]) begin
                cp[p] = tg;
                set_cmpl(p, tg, 1'b0);
                break;
              end
            end
          end
        end
        #1;
        chk(ret_valid_o == 4'((1 << exp_n) - 1), "R4", int'(ret_valid_o), (1 << exp_n) - 1);
        for (int r = 0; r < exp_n; r++) begin
          chk(ret_tag_o[r*5 +: 5] == 5'(q[r]) && ret_ldst_o[r*5 +: 5] == m_ldst[q[r]],
              "R4", int'(ret_tag_o[r*5 +: 5]), q[r]);
          chk(free_valid_o[r] == m_has[q[r]], "R6", int'(free_valid_o[r]), int'(m_has[q[r]]));
          if (m_has[q[r]])
            chk(free_preg_o[r*7 +: 7] == m_preg[q[r]], "R6",
                int'(free_preg_o[r*7 +: 7]), int'(m_preg[q[r]]));
        end
        if (k > 0) begin
          chk(alloc_accept_o == acc, "R2", int'(alloc_accept_o), int'(acc));
          chk(alloc_tag_o[4:0] == 5'(mt), "R2", int'(alloc_tag_o[4:0]), mt);
        end
        chk(full_o == (q.size() == 32), "R3", int'(full_o), int'(q.size() == 32));
        tick();
        for (int r = 0; r < exp_n; r++) void'(q.pop_front());
        if (acc)
          for (int i = 0; i < k; i++) begin
            int s;
            s = (mt + i) % 32;
            m_ldst[s] = alloc_ldst_i[i*5 +: 5];
            m_has[s]  = alloc_has_old_i[i];
            m_preg[s] = alloc_old_preg_i[i*7 +: 7];
            m_done[s] = 1'b0;
            q.push_back(s);
          end
        if (acc) mt = (mt + k) % 32;
        for (int p = 0; p < 2; p++) if (cp[p] >= 0) m_done[cp[p]] = 1'b1;
      end
    end

    idle();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule